// File: doc/BRIEF.md
# DMA Channel Interrupt and Control Status Unit

This block collects per-channel events from a multi-channel DMA engine and turns them into sticky status flags and interrupt lines. It has three registers behind a simple register port: a completion register, an error register and a channel control register. Each channel reports three kinds of single-cycle pulse: completion, termination and bus error. The unit latches them and masks completions with per-channel enables. It then drives one registered interrupt line per channel.

Software acknowledges flags and changes control bits through alias addresses that only set or only clear the bits written as 1. No read-modify-write cycle is needed, so an event that arrives during an acknowledge is not lost. In the error register, a termination sets only a low flag bit, while a bus error also sets a high kind bit. The sum of the two bits therefore gives the cause of the error. The control register holds a freeze bit and a reset bit for each channel. A reset bit drops by itself once the channel reports that it is idle.

Top module: `dmairq_status_unit`

## Requirements
- R1: After a synchronous active-high reset, all three registers read 0 and every irq, freeze and reset output is low.
- R2: A pulse on ch_done[n] sets bit n of the completion register (register base 0x00). The bit stays set until software clears it. Bits 31:16 of that register are the completion interrupt enables, where bit n+16 enables channel n.
- R3: The error register is at base 0x10. A pulse on ch_term[n] sets only bit n. A pulse on ch_buserr[n] sets both bit n and bit n+16. Bit n plus bit n+16 therefore reads 0 for no error, 1 for a termination and 2 for a bus error.
- R4: Each register has three write offsets. A write at base+0x0 replaces the register. A write at base+0x4 ORs in the 1 bits of the data. A write at base+0x8 clears the 1 bits of the data. A read at any of these three offsets returns the register value.
- R5: ch_irq[n] becomes (completion bit n AND enable bit n+16) OR error bit n, one clock after the register holds that value.
- R6: When an event pulse and a write to the clear offset hit the same bit in the same cycle, the bit ends up set.
- R7: The control register is at base 0x20. Bit n drives ch_freeze[n] and bit n+16 drives ch_reset[n], with no added delay.
- R8: While ch_reset[n] is high and ch_idle[n] is high at a clock edge, the reset bit clears at that edge. Freeze bits are not affected by ch_idle.
- R9: Writes at offset 0xC of any register, or at addresses 0x30 to 0x3F, change nothing. Reads at those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ch_done | input | 16 | Per-channel completion pulses |
| ch_term | input | 16 | Per-channel termination pulses |
| ch_buserr | input | 16 | Per-channel bus-error pulses |
| ch_idle | input | 16 | Per-channel idle indication |
| ch_irq | output | 16 | Per-channel interrupt lines, registered |
| ch_freeze | output | 16 | Per-channel freeze controls |
| ch_reset | output | 16 | Per-channel reset requests |

## Verification
A wrong flag value shows up at bus_rdata in the cycle right after the edge that wrote it. It shows up on ch_irq one clock later, so the bench reads each register before it looks at the interrupt line. Every channel is swept one at a time through each event kind and each alias, so a wrong bit index or a swapped error half appears as a mismatch in a single named position. Control bits go straight to ch_freeze and ch_reset, so any error in the self-clear rule is visible at the ports in the same cycle.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int unsigned ADDR_W = 6;

    typedef enum logic [1:0] {
        SEL_DONE = 2'd0,
        SEL_ERR  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        WR_PLAIN = 2'd0,
        WR_SET   = 2'd1,
        WR_CLR   = 2'd2,
        WR_NONE  = 2'd3
    } wr_mode_e;

    function automatic reg_sel_e addr_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[5:4]);
    endfunction

    function automatic wr_mode_e addr_mode(input logic [ADDR_W-1:0] a);
        return wr_mode_e'(a[3:2]);
    endfunction

endpackage

// File: rtl/dmairq_alias_reg.sv
module dmairq_alias_reg
    import dmairq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  wr_mode_e     wr_mode,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] q
);

    logic [W-1:0] sw_next;
    logic [W-1:0] nxt;

    always_comb begin
        sw_next = q;
        if (wr_en) begin
            case (wr_mode)
                WR_PLAIN: sw_next = wr_data;
                WR_SET:   sw_next = q | wr_data;
                WR_CLR:   sw_next = q & ~wr_data;
                default:  sw_next = q;
            endcase
        end
        // hardware events are applied last so they override a software clear
        nxt = (sw_next & ~hw_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));

    assert_clear_alias_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_mode == WR_CLR && hw_set == '0) |=> ((q & $past(wr_data)) == '0));

endmodule

// File: rtl/dmairq_irq_out.sv
module dmairq_irq_out #(
    parameter int unsigned NCH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2*NCH-1:0] done_q,
    input  logic [2*NCH-1:0] err_q,
    output logic [NCH-1:0]   irq
);

    logic [NCH-1:0] irq_d;

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            assign irq_d[n] = (done_q[n] & done_q[n+NCH]) | err_q[n];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq <= '0;
        else     irq <= irq_d;
    end

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (((done_q[NCH-1:0] & done_q[2*NCH-1:NCH]) | err_q[NCH-1:0]) == '0) |=> (irq == '0));

endmodule

// File: rtl/dmairq_status_unit.sv
module dmairq_status_unit
    import dmairq_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [5:0]         bus_addr,
    input  logic [2*NCH-1:0]   bus_wdata,
    output logic [2*NCH-1:0]   bus_rdata,
    input  logic [NCH-1:0]     ch_done,
    input  logic [NCH-1:0]     ch_term,
    input  logic [NCH-1:0]     ch_buserr,
    input  logic [NCH-1:0]     ch_idle,
    output logic [NCH-1:0]     ch_irq,
    output logic [NCH-1:0]     ch_freeze,
    output logic [NCH-1:0]     ch_reset
);

    localparam int unsigned DW = 2 * NCH;

    reg_sel_e       sel;
    wr_mode_e       mode;
    logic           wr_ok;
    logic [DW-1:0]  done_q;
    logic [DW-1:0]  err_q;
    logic [DW-1:0]  ctrl_q;
    logic [DW-1:0]  ctrl_hw_clr;

    assign sel   = addr_sel(bus_addr);
    assign mode  = addr_mode(bus_addr);
    assign wr_ok = bus_we && (mode != WR_NONE);

    assign ctrl_hw_clr = {ctrl_q[DW-1:NCH] & ch_idle, {NCH{1'b0}}};

    dmairq_alias_reg #(.W(DW)) u_done (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok && sel == SEL_DONE), .wr_mode(mode), .wr_data(bus_wdata),
        .hw_set({{NCH{1'b0}}, ch_done}), .hw_clr('0), .q(done_q)
    );

    dmairq_alias_reg #(.W(DW)) u_err (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok && sel == SEL_ERR), .wr_mode(mode), .wr_data(bus_wdata),
        .hw_set({ch_buserr, ch_term | ch_buserr}), .hw_clr('0), .q(err_q)
    );

    dmairq_alias_reg #(.W(DW)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok && sel == SEL_CTRL), .wr_mode(mode), .wr_data(bus_wdata),
        .hw_set('0), .hw_clr(ctrl_hw_clr), .q(ctrl_q)
    );

    dmairq_irq_out #(.NCH(NCH)) u_irq (
        .clk(clk), .rst(rst), .done_q(done_q), .err_q(err_q), .irq(ch_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (mode != WR_NONE) begin
            case (sel)
                SEL_DONE: bus_rdata = done_q;
                SEL_ERR:  bus_rdata = err_q;
                SEL_CTRL: bus_rdata = ctrl_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign ch_freeze = ctrl_q[NCH-1:0];
    assign ch_reset  = ctrl_q[DW-1:NCH];

    assert_reset_selfclear_R8: assert property (@(posedge clk) disable iff (rst)
        (!(bus_we && sel == SEL_CTRL) && ((ch_reset & ch_idle) != '0))
        |=> ((ch_reset & $past(ch_reset & ch_idle)) == '0));

    assert_buserr_kind_R3: assert property (@(posedge clk) disable iff (rst)
        (ch_buserr != '0)
        |=> ((err_q & {$past(ch_buserr), $past(ch_buserr)}) == {$past(ch_buserr), $past(ch_buserr)}));

    assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_NONE && ch_idle == '0) |=> $stable(ctrl_q));

endmodule

// File: tb/dmairq_status_unit_bench.sv
module dmairq_status_unit_bench;

    localparam int NCH = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic [5:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  ch_done = '0, ch_term = '0, ch_buserr = '0, ch_idle = '0;
    logic [NCH-1:0]  ch_irq, ch_freeze, ch_reset;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dmairq_status_unit #(.NCH(NCH)) u_dmairq_status_unit (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_done(ch_done), .ch_term(ch_term), .ch_buserr(ch_buserr), .ch_idle(ch_idle),
        .ch_irq(ch_irq), .ch_freeze(ch_freeze), .ch_reset(ch_reset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] tm, input logic [NCH-1:0] be);
        ch_done = dn; ch_term = tm; ch_buserr = be;
        @(negedge clk);
        ch_done = '0; ch_term = '0; ch_buserr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, r); chk("R1 done reg", r, 32'h0);
        rd(6'h10, r); chk("R1 err reg", r, 32'h0);
        rd(6'h20, r); chk("R1 ctrl reg", r, 32'h0);
        chk("R1 outputs", {ch_irq, ch_freeze}, 32'h0);
        chk("R1 reset out", {16'h0, ch_reset}, 32'h0);

        // R2, R5, R4: completion per channel, enable via set alias, ack via clear alias
        for (int n = 0; n < NCH; n++) begin
            pulse(16'(1 << n), '0, '0);
            rd(6'h00, r); chk("R2 done sticky", r, 32'(1) << n);
            @(negedge clk);
            rd(6'h00, r); chk("R2 done held", r, 32'(1) << n);
            chk("R5 masked irq", {16'h0, ch_irq}, 32'h0);
            wr(6'h04, 32'(1) << (n + 16));
            rd(6'h00, r); chk("R4 set alias", r, (32'(1) << n) | (32'(1) << (n + 16)));
            @(negedge clk);
            chk("R5 enabled irq", {16'h0, ch_irq}, 32'(1) << n);
            wr(6'h08, (32'(1) << n) | (32'(1) << (n + 16)));
            rd(6'h08, r); chk("R4 clear alias", r, 32'h0);
            @(negedge clk);
            chk("R5 irq drops", {16'h0, ch_irq}, 32'h0);
        end

        // R3, R5: termination and bus error per channel
        for (int n = 0; n < NCH; n++) begin
            pulse('0, 16'(1 << n), '0);
            rd(6'h10, r); chk("R3 term flag", r, 32'(1) << n);
            chk("R3 term code", 32'(r[n]) + 32'(r[n+16]), 32'd1);
            @(negedge clk);
            chk("R5 err irq", {16'h0, ch_irq}, 32'(1) << n);
            wr(6'h18, 32'(1) << n);
            pulse('0, '0, 16'(1 << n));
            rd(6'h14, r); chk("R3 buserr flags", r, (32'(1) << n) | (32'(1) << (n + 16)));
            chk("R3 buserr code", 32'(r[n]) + 32'(r[n+16]), 32'd2);
            wr(6'h18, 32'hFFFF_FFFF);
            rd(6'h10, r); chk("R3 err cleared", r, 32'h0);
        end
        @(negedge clk);
        chk("R5 all quiet", {16'h0, ch_irq}, 32'h0);

        // R4: plain write replaces the whole register
        wr(6'h00, 32'hA5A5_00FF);
        wr(6'h00, 32'h0000_1234);
        rd(6'h00, r); chk("R4 plain replace", r, 32'h0000_1234);
        wr(6'h04, 32'h0001_0000);
        rd(6'h04, r); chk("R4 set keeps others", r, 32'h0001_1234);
        wr(6'h00, 32'h0000_000F);

        // R6: event and clear in the same cycle
        ch_done = 16'h00F0;
        wr(6'h08, 32'h0000_00FF);
        ch_done = '0;
        rd(6'h00, r); chk("R6 done set wins", r, 32'h0000_00F0);
        ch_buserr = 16'h0020;
        wr(6'h18, 32'hFFFF_FFFF);
        ch_buserr = '0;
        rd(6'h10, r); chk("R6 err set wins", r, 32'h0020_0020);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h08, 32'hFFFF_FFFF);

        // R7, R8: freeze and reset controls
        ch_idle = 16'hFFFF;
        wr(6'h24, 32'h0000_00A5);
        chk("R7 freeze out", {16'h0, ch_freeze}, 32'h0000_00A5);
        repeat (2) @(negedge clk);
        chk("R8 freeze ignores idle", {16'h0, ch_freeze}, 32'h0000_00A5);
        ch_idle = '0;
        wr(6'h24, 32'h00FF_0000);
        chk("R7 reset out", {16'h0, ch_reset}, 32'h0000_00FF);
        repeat (3) @(negedge clk);
        chk("R8 reset held while busy", {16'h0, ch_reset}, 32'h0000_00FF);
        ch_idle = 16'h0005;
        @(negedge clk);
        ch_idle = '0;
        chk("R8 reset self clear", {16'h0, ch_reset}, 32'h0000_00FA);
        rd(6'h20, r); chk("R7 ctrl readback", r, 32'h00FA_00A5);
        wr(6'h28, 32'hFFFF_FFFF);
        rd(6'h20, r); chk("R7 ctrl cleared", r, 32'h0);

        // R9: unmapped writes and reads
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h2C, 32'hFFFF_FFFF);
        wr(6'h30, 32'hFFFF_FFFF);
        wr(6'h34, 32'hFFFF_FFFF);
        rd(6'h00, r); chk("R9 done untouched", r, 32'h0);
        rd(6'h20, r); chk("R9 ctrl untouched", r, 32'h0);
        chk("R9 outputs untouched", {ch_freeze, ch_reset}, 32'h0);
        rd(6'h30, r); chk("R9 unmapped read", r, 32'h0);
        rd(6'h1C, r); chk("R9 offset C read", r, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule